// File: doc/BRIEF.md
# Ramp Tone Generator

This block produces a stepped ramp (sawtooth) level for a sound channel. A programmable period divider runs on a per-CPU-cycle advance strobe. Every time the divider expires it toggles a one-bit phase, and whenever that phase returns to zero a programmable rate is added to an accumulator. A small stage counter tracks these additions. When the stage counter reaches its clear value, it empties the accumulator, so the ramp restarts. The audible level is the upper part of the accumulator, or zero while the channel is switched off.

Software programs the channel through three byte-wide write slots. One slot holds the rate, one holds the low byte of the period, and one holds the upper period bits together with the on/off bit. A fourth select value is decoded but changes nothing. Mixing with other channels and conversion to analogue are left to the surrounding logic.

Top module: `ramp_tone`

## Requirements
- R1: After reset, the level output is 0. The divider holds 1. Phase, stage, accumulator, rate, period and the on bit all hold 0. So with period 0, the first advance only toggles the phase, and the second advance makes the first addition.
- R2: A write with select 0 loads the rate from data bits 5:0. Data bits 7:6 are ignored.
- R3: A write with select 1 loads period bits 7:0. A write with select 2 loads period bits 11:8 from data bits 3:0 and the on bit from data bit 7, and data bits 6:4 are ignored. A write with select 3 changes nothing.
- R4: The divider moves only on a cycle with the advance strobe high. If the divider holds 1, it reloads to (period+1) mod 4096 and the phase toggles. Otherwise it decrements mod 4096. A period of 0xFFF therefore gives 4096 advances per phase half.
- R5: When the phase toggles back to 0, the rate is added to the 8-bit accumulator modulo 256, with no saturation, and the stage counter increments.
- R6: When the stage counter reaches 7, the stage counter and the accumulator are both cleared. A ramp therefore shows six nonzero additions and then returns to 0.
- R7: The level output equals accumulator bits 7:3 while the on bit is set, and 0 while it is clear. The divider, phase and accumulator keep running while the channel is off.
- R8: A period write does not restart the divider. The new value first takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Advance strobe, one per CPU cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 rate, 1 period low, 2 period high and on bit, 3 unused) |
| wr_data_i | input | 8 | Register write data |
| level_o | output | 5 | Ramp level |

## Verification
A directed ramp with period 0 and rate 8 makes every addition visible as a level step of one. This shows the two-expiries-per-addition spacing and the clear on the seventh stage. A rate of 63 pushes the accumulator past 255, which separates modulo wrap from saturation. Periods of 3, 0x103 and 0xFFF separate decrement-and-reload timing from restart-on-write, and also test the upper period bits and the 4096 reload case. Random stretches mix sparse and dense advance strobes with writes to every select, including masked bits and the unused slot. A bench model checks the level on every cycle, so any drift in ordering between a write and an advance in the same cycle shows up.

// File: rtl/ramp_tone_pkg.sv
package ramp_tone_pkg;

   typedef enum logic [1:0] {
      SEL_RATE   = 2'd0,
      SEL_PER_LO = 2'd1,
      SEL_PER_HI = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ON_BIT = 7;

endpackage

// File: rtl/ramp_tone_regs.sv
module ramp_tone_regs
   import ramp_tone_pkg::*;
#(
   parameter int unsigned PERIOD_W = 12,
   parameter int unsigned RATE_W   = 6
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  reg_sel_e            wr_sel_i,
   input  logic [BYTE_W-1:0]   wr_data_i,
   output logic [RATE_W-1:0]   rate_o,
   output logic [PERIOD_W-1:0] period_o,
   output logic                on_o
);

   logic [RATE_W-1:0] rate_q;
   logic              on_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rate_q <= '0;
         on_q   <= 1'b0;
      end else if (wr_en_i) begin
         if (wr_sel_i == SEL_RATE)   rate_q <= wr_data_i[RATE_W-1:0];
         if (wr_sel_i == SEL_PER_HI) on_q   <= wr_data_i[ON_BIT];
      end
   end

   generate
      if (PERIOD_W > BYTE_W) begin : g_split
         localparam int unsigned HI_W = PERIOD_W - BYTE_W;
         logic [BYTE_W-1:0] lo_q;
         logic [HI_W-1:0]   hi_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               lo_q <= '0;
               hi_q <= '0;
            end else if (wr_en_i) begin
               if (wr_sel_i == SEL_PER_LO) lo_q <= wr_data_i;
               if (wr_sel_i == SEL_PER_HI) hi_q <= wr_data_i[HI_W-1:0];
            end
         end
         assign period_o = {hi_q, lo_q};
      end else begin : g_single
         logic [PERIOD_W-1:0] per_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)                               per_q <= '0;
            else if (wr_en_i && wr_sel_i == SEL_PER_LO) per_q <= wr_data_i[PERIOD_W-1:0];
         end
         assign period_o = per_q;
      end
   endgenerate

   assign rate_o = rate_q;
   assign on_o   = on_q;

   // R2: rate only changes on a rate write
   a_r2_rate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == SEL_RATE) |=> $stable(rate_o));

   // R3: period only changes on a period write
   a_r3_period_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && (wr_sel_i == SEL_PER_LO || wr_sel_i == SEL_PER_HI)) |=> $stable(period_o));

   // R3: the unused select touches nothing
   a_r3_spare_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == SEL_SPARE) |=> $stable({rate_o, period_o, on_o}));

endmodule

// File: rtl/ramp_tone_div.sv
module ramp_tone_div #(
   parameter int unsigned PERIOD_W = 12
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                tick_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                step_o
);

   logic [PERIOD_W-1:0] div_q;
   logic                phase_q;
   logic                expire;

   assign expire = (div_q == PERIOD_W'(1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         div_q   <= PERIOD_W'(1);
         phase_q <= 1'b0;
      end else if (tick_i) begin
         if (expire) begin
            div_q   <= period_i + 1'b1;
            phase_q <= ~phase_q;
         end else begin
            div_q   <= div_q - 1'b1;
         end
      end
   end

   // an addition happens when the phase wraps from 1 back to 0
   assign step_o = tick_i && expire && phase_q;

   // R4: reload value on expiry
   a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && div_q == PERIOD_W'(1)) |=> (div_q == PERIOD_W'($past(period_i) + 1'b1)) && (phase_q != $past(phase_q)));

   // R4: plain decrement keeps the phase
   a_r4_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && div_q != PERIOD_W'(1)) |=> (div_q == PERIOD_W'($past(div_q) - 1'b1)) && $stable(phase_q));

   // R4: no advance, no motion
   a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(div_q) && $stable(phase_q));

   // R5: a step leaves the phase at 0
   a_r5_step_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_o |=> (phase_q == 1'b0));

endmodule

// File: rtl/ramp_tone_accum.sv
module ramp_tone_accum #(
   parameter int unsigned RATE_W      = 6,
   parameter int unsigned ACC_W       = 8,
   parameter int unsigned STAGE_W     = 3,
   parameter int unsigned STAGE_CLEAR = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic [ACC_W-1:0]  acc_o
);

   localparam int unsigned PAD_W = ACC_W - RATE_W;

   logic [STAGE_W-1:0] stage_q;
   logic [STAGE_W-1:0] stage_inc;
   logic [ACC_W-1:0]   acc_q;
   logic [ACC_W-1:0]   rate_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign rate_ext = {{PAD_W{1'b0}}, rate_i};
      end else begin : g_nopad
         assign rate_ext = rate_i;
      end
   endgenerate

   assign stage_inc = stage_q + 1'b1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         stage_q <= '0;
         acc_q   <= '0;
      end else if (step_i) begin
         if (stage_inc == STAGE_W'(STAGE_CLEAR)) begin
            stage_q <= '0;
            acc_q   <= '0;
         end else begin
            stage_q <= stage_inc;
            acc_q   <= acc_q + rate_ext;
         end
      end
   end

   assign acc_o = acc_q;

   // R5: modulo addition on a non-final step
   a_r5_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && stage_q != STAGE_W'(STAGE_CLEAR - 1)) |=> (acc_q == ACC_W'($past(acc_q) + $past(rate_ext))));

   // R5: no step, accumulator still
   a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> $stable(acc_q) && $stable(stage_q));

   // R6: final step clears both
   a_r6_wrap_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && stage_q == STAGE_W'(STAGE_CLEAR - 1)) |=> (acc_q == '0) && (stage_q == '0));

   // R6: the clear value is never held
   a_r6_stage_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_q != STAGE_W'(STAGE_CLEAR));

   // R6: stage 0 always pairs with an empty accumulator
   a_r6_empty_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stage_q == '0) |-> (acc_q == '0));

endmodule

// File: rtl/ramp_tone.sv
module ramp_tone
   import ramp_tone_pkg::*;
#(
   parameter int unsigned PERIOD_W    = 12,
   parameter int unsigned RATE_W      = 6,
   parameter int unsigned ACC_W       = 8,
   parameter int unsigned STAGE_W     = 3,
   parameter int unsigned STAGE_CLEAR = 7,
   parameter int unsigned OUT_SHIFT   = 3
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       tick_i,
   input  logic                       wr_en_i,
   input  logic [1:0]                 wr_sel_i,
   input  logic [7:0]                 wr_data_i,
   output logic [ACC_W-OUT_SHIFT-1:0] level_o
);

   localparam int unsigned LEVEL_W = ACC_W - OUT_SHIFT;

   generate
      if (PERIOD_W < 1 || PERIOD_W > BYTE_W + ON_BIT) begin : g_bad_period
         $error("ramp_tone: PERIOD_W out of range");
      end
      if (RATE_W < 1 || RATE_W > ON_BIT || RATE_W > ACC_W) begin : g_bad_rate
         $error("ramp_tone: RATE_W out of range");
      end
      if (OUT_SHIFT >= ACC_W) begin : g_bad_shift
         $error("ramp_tone: OUT_SHIFT must be below ACC_W");
      end
      if (STAGE_CLEAR < 1 || STAGE_CLEAR >= (1 << STAGE_W)) begin : g_bad_stage
         $error("ramp_tone: STAGE_CLEAR must fit STAGE_W");
      end
   endgenerate

   logic [RATE_W-1:0]   rate;
   logic [PERIOD_W-1:0] period;
   logic                on;
   logic                step;
   logic [ACC_W-1:0]    acc;

   ramp_tone_regs #(.PERIOD_W(PERIOD_W), .RATE_W(RATE_W)) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (reg_sel_e'(wr_sel_i)),
      .wr_data_i (wr_data_i),
      .rate_o    (rate),
      .period_o  (period),
      .on_o      (on)
   );

   ramp_tone_div #(.PERIOD_W(PERIOD_W)) div_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .period_i (period),
      .step_o   (step)
   );

   ramp_tone_accum #(
      .RATE_W(RATE_W), .ACC_W(ACC_W), .STAGE_W(STAGE_W), .STAGE_CLEAR(STAGE_CLEAR)
   ) accum_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step),
      .rate_i (rate),
      .acc_o  (acc)
   );

   always_comb begin
      level_o = on ? acc[ACC_W-1:OUT_SHIFT] : '0;
   end

   // R7: the level moves only with a step or an on-bit change
   a_r7_level_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step && !(wr_en_i && wr_sel_i == 2'd2)) |=> $stable(level_o));

   // R1: level is cleared by reset
   a_r1_reset_quiet: assert property (@(posedge clk_i)
      !rst_ni |=> (level_o == LEVEL_W'(0)));

endmodule

// File: tb/ramp_tone_tb_top.sv
`timescale 1ns/1ps
module ramp_tone_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [4:0] level;

   int unsigned vectors = 0;
   int unsigned fails = 0;
   bit          done = 1'b0;

   // reference state
   logic [11:0] m_div;
   logic [11:0] m_per;
   logic        m_ph;
   logic [2:0]  m_st;
   logic [7:0]  m_acc;
   logic [5:0]  m_rate;
   logic        m_on;

   always #2.5 clk = ~clk;

   ramp_tone dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick_i    (tick),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .level_o   (level)
   );

   function automatic logic [4:0] model_level();
      return m_on ? m_acc[7:3] : 5'd0;
   endfunction

   task automatic model_reset();
      m_div = 12'd1; m_per = '0; m_ph = 1'b0; m_st = '0;
      m_acc = '0; m_rate = '0; m_on = 1'b0;
   endtask

   task automatic model_update(input logic tk, input logic we,
                               input logic [1:0] sel, input logic [7:0] d);
      if (tk) begin
         if (m_div == 12'd1) begin
            m_div = m_per + 12'd1;
            m_ph  = ~m_ph;
            if (m_ph == 1'b0) begin
               m_acc = m_acc + {2'b00, m_rate};
               m_st  = m_st + 3'd1;
               if (m_st == 3'd7) begin
                  m_st  = '0;
                  m_acc = '0;
               end
            end
         end else begin
            m_div = m_div - 12'd1;
         end
      end
      if (we) begin
         case (sel)
            2'd0: m_rate = d[5:0];
            2'd1: m_per[7:0] = d;
            2'd2: begin m_per[11:8] = d[3:0]; m_on = d[7]; end
            default: ;
         endcase
      end
   endtask

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: level got %0d expected %0d", tag, act, exp);
      end
   endtask

   // one cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge
   task automatic apply(input logic tk, input logic we,
                        input logic [1:0] sel, input logic [7:0] d);
      tick = tk; wr_en = we; wr_sel = sel; wr_data = d;
      @(posedge clk);
      model_update(tk, we, sel, d);
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      check("R7 model", level, model_level());
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) apply(1'b1, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      apply(1'b0, 1'b1, sel, d);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         summary();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset level", level, 5'd0);

      // R2: upper rate bits ignored, rate becomes 8
      wr(2'd0, 8'hC8);
      wr(2'd2, 8'h80);
      ticks(1);
      check("R1 first advance only toggles phase", level, 5'd0);
      ticks(1);
      check("R2 rate from bits 5:0", level, 5'd1);
      for (int k = 2; k <= 7; k++) begin
         ticks(2);
         check("R6 ramp step", level, (k == 7) ? 5'd0 : 5'(k));
      end

      // R7: off channel is silent but keeps counting
      wr(2'd2, 8'h00);
      check("R7 off is silent", level, 5'd0);
      ticks(2);
      check("R7 off still silent", level, 5'd0);
      wr(2'd2, 8'h80);
      check("R7 counted while off", level, 5'd1);

      // R3: unused select
      wr(2'd3, 8'hFF);
      check("R3 spare write inert", level, 5'd1);
      ticks(2);
      check("R3 rate kept after spare write", level, 5'd2);

      // R5: modulo wrap with rate 63, acc 16 -> 79,142,205,12
      wr(2'd0, 8'h3F);
      ticks(8);
      check("R5 modulo wrap", level, 5'd1);
      ticks(2);
      check("R6 clear at stage 7", level, 5'd0);

      // R4/R8: period 3, divider currently 1
      wr(2'd1, 8'h03);
      ticks(1);
      for (int i = 0; i < 3; i++) apply(1'b0, 1'b0, 2'd0, 8'd0);
      check("R4 idle cycles hold", level, 5'd0);
      ticks(3);
      check("R4 no step before reload count", level, 5'd0);
      ticks(1);
      check("R4 step after period+1", level, 5'd7);

      // R3/R8: high period bits, old reload still honoured
      wr(2'd2, 8'hF1);
      ticks(4 + 259);
      check("R8 new period waits for reload", level, 5'd7);
      ticks(1);
      check("R3 high period bits", level, 5'd15);

      // R4: period 0xFFF reloads to 0 then runs 4096 advances
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h8F);
      ticks(260 + 4095);
      check("R4 full period no step yet", level, 5'd15);
      ticks(1);
      check("R4 period 0xFFF step", level, 5'd23);

      // random mix
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h80);
      for (int n = 0; n < 4000; n++) begin
         logic       tk;
         logic       we;
         logic [1:0] sel;
         logic [7:0] d;
         tk  = (($urandom % 4) != 0);
         we  = (($urandom % 8) == 0);
         sel = 2'($urandom % 4);
         d   = 8'($urandom);
         if (sel == 2'd1) d = d & 8'h07;
         if (sel == 2'd2) d = d & 8'hF0;
         apply(tk, we, sel, d);
      end

      done = 1'b1;
      summary();
   end

endmodule